// File: doc/BRIEF.md
# Time-Multiplexed FM Slot Sequencer

This block drives the schedule of a single shared FM operator datapath that serves sixteen voices of six operators each. Every clock cycle is one slot. A voice counter and an operator counter step through the 96 slots of an update frame. The operator index counts downward from 6 to 1. All sixteen voices are served for one operator before the next lower operator starts. This places successive operators of any one voice exactly sixteen cycles apart, which is the latency budget that every per-voice path downstream must meet.

Phase state is held in a circular 96-stage delay line of 22-bit accumulators, not in addressable memory. The value leaving the line belongs to the slot being served. It has that slot's frequency increment added and re-enters the line, and its top 12 bits go out as the sine table index. A CPU-written algorithm number selects one of 32 algorithms. The number is latched only at a frame boundary. For each slot, the block looks up a 9-bit control word for the active algorithm and the current operator, and presents that word to the modulation stage as separate fields.

Top module: `fm_slot_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after the synchronized release, the block presents slot 0: voice index 0, operator index 6, active algorithm code 0, and every stored phase zero, so that `ph_index` equals bits [21:10] of `freq_inc`.
- R2: `voice_idx` advances by one every cycle and wraps from 15 to 0.
- R3: `op_idx` holds for sixteen cycles, then moves to the next lower operator in the order 6, 5, 4, 3, 2, 1, and after operator 1 returns to 6. The frame is 96 cycles long.
- R4: Each slot's accumulator equals that slot's value from 96 cycles earlier plus the current `freq_inc`, modulo 2^22. `ph_index` is bits [21:10] of the updated value.
- R5: The control outputs are the 9-bit ROM word for the active algorithm code and the current `op_idx`. The word is packed MSB first as {sel[2:0], A, C, D, com[2:0]}, and the fields appear on `ctl_sel`, `ctl_fb_load` (A), `ctl_mem_hold` (C), `ctl_mem_load` (D) and `ctl_com`.
- R6: Algorithm code k selects algorithm k+1. For code 7 (algorithm 8), the words for operators 6 down to 1, written sel/ACD/com, are 1/000/0, 5/001/0, 2/111/1, 0/001/0, 1/010/1, 0/011/0.
- R7: For code 0, the words for operators 6 down to 1 are 1/100/0, 1/000/0, 1/000/1, 0/001/0, 1/010/1, 5/011/0. For code 1, they are 1/000/0, 1/000/0, 1/000/1, 5/001/0, 1/110/1, 0/011/0.
- R8: Every other algorithm code returns the all-zero word for every operator.
- R9: A write (`alg_wr_en` high) in any slot, including slot 95, changes the active algorithm starting at the next slot 0 and in no earlier slot. When several writes fall in one frame, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| freq_inc | input | 22 | Frequency increment for the current slot |
| alg_wr_en | input | 1 | Algorithm write strobe |
| alg_wr_num | input | 5 | Algorithm code (algorithm number minus one) |
| ph_index | output | 12 | Top bits of the updated phase of the current slot |
| voice_idx | output | 4 | Voice of the current slot, 0 to 15 |
| op_idx | output | 3 | Operator of the current slot, 6 down to 1 |
| ctl_sel | output | 3 | Modulation source selector |
| ctl_fb_load | output | 1 | Feedback register load enable (A) |
| ctl_mem_hold | output | 1 | Memory register keep enable (C) |
| ctl_mem_load | output | 1 | Memory register input enable (D) |
| ctl_com | output | 3 | Output count minus one, for level compensation |

## Verification
The bench targets the operator wrap from 1 back to 6. A counter that got this wrong would produce a frame of the wrong length or an operator 0 slot. It also drives increments that overflow 22 bits, which catches an accumulator that saturates or keeps a carry. A phase line one stage too short or too long shows up as phase values drifting into the wrong slots. Algorithm writes are placed mid-frame, in slot 95, and twice within one frame. A design that latches immediately would change the control words partway through a frame, and one that ignores a late write or keeps the first write would show the wrong algorithm in the next frame.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;

  localparam int ALG_W  = 5;
  localparam int CTL_W  = 9;

  typedef struct packed {
    logic [2:0] sel;
    logic       fb_ld;
    logic       mem_hold;
    logic       mem_ld;
    logic [2:0] com;
  } ctl_word_t;

endpackage

// File: rtl/fmseq_rst_sync.sv
module fmseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/fmseq_slot_counter.sv
module fmseq_slot_counter #(
  parameter int NUM_VOICES = 16,
  parameter int NUM_OPS    = 6,
  localparam int VW = $clog2(NUM_VOICES),
  localparam int OW = $clog2(NUM_OPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [VW-1:0] voice,
  output logic [OW-1:0] op,
  output logic          frame_last
);

  localparam logic [VW-1:0] VOICE_LAST = VW'(NUM_VOICES - 1);
  localparam logic [OW-1:0] OP_TOP     = OW'(NUM_OPS);
  localparam logic [OW-1:0] OP_BOTTOM  = OW'(1);

  logic [VW-1:0] voice_q, voice_d;
  logic [OW-1:0] op_q, op_d;
  logic          voice_wrap;

  always_comb begin
    voice_wrap = (voice_q == VOICE_LAST);
    voice_d    = voice_wrap ? '0 : voice_q + VW'(1);
    op_d       = op_q;
    if (voice_wrap) begin
      op_d = (op_q == OP_BOTTOM) ? OP_TOP : op_q - OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voice_q <= '0;
      op_q    <= OP_TOP;
    end else begin
      voice_q <= voice_d;
      op_q    <= op_d;
    end
  end

  assign voice      = voice_q;
  assign op         = op_q;
  assign frame_last = voice_wrap && (op_q == OP_BOTTOM);

endmodule

// File: rtl/fmseq_phase_ring.sv
module fmseq_phase_ring #(
  parameter int DEPTH = 96,
  parameter int PH_W  = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] inc,
  output logic [PH_W-1:0] acc_new
);

  logic [PH_W-1:0] stage_q [DEPTH];

  assign acc_new = stage_q[DEPTH-1] + inc;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [PH_W-1:0] stage_d;
      if (g == 0) begin : g_head
        assign stage_d = acc_new;
      end else begin : g_body
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

endmodule

// File: rtl/fmseq_alg_rom.sv
module fmseq_alg_rom
  import fmseq_pkg::*;
#(
  parameter int OW = 3
) (
  input  logic [ALG_W-1:0] alg,
  input  logic [OW-1:0]    op,
  output ctl_word_t        word
);

  logic [CTL_W-1:0] raw;

  always_comb begin
    raw = '0;
    unique case (alg)
      ALG_W'(0): begin
        case (op)
          OW'(6): raw = 9'b001_100_000;
          OW'(5): raw = 9'b001_000_000;
          OW'(4): raw = 9'b001_000_001;
          OW'(3): raw = 9'b000_001_000;
          OW'(2): raw = 9'b001_010_001;
          OW'(1): raw = 9'b101_011_000;
          default: raw = '0;
        endcase
      end
      ALG_W'(1): begin
        case (op)
          OW'(6): raw = 9'b001_000_000;
          OW'(5): raw = 9'b001_000_000;
          OW'(4): raw = 9'b001_000_001;
          OW'(3): raw = 9'b101_001_000;
          OW'(2): raw = 9'b001_110_001;
          OW'(1): raw = 9'b000_011_000;
          default: raw = '0;
        endcase
      end
      ALG_W'(7): begin
        case (op)
          OW'(6): raw = 9'b001_000_000;
          OW'(5): raw = 9'b101_001_000;
          OW'(4): raw = 9'b010_111_001;
          OW'(3): raw = 9'b000_001_000;
          OW'(2): raw = 9'b001_010_001;
          OW'(1): raw = 9'b000_011_000;
          default: raw = '0;
        endcase
      end
      default: raw = '0;
    endcase
  end

  assign word = ctl_word_t'(raw);

endmodule

// File: rtl/fm_slot_sequencer.sv
module fm_slot_sequencer
  import fmseq_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int NUM_OPS    = 6,
  parameter int PH_W       = 22,
  parameter int IDX_W      = 12,
  localparam int NUM_SLOTS = NUM_VOICES * NUM_OPS,
  localparam int VW        = $clog2(NUM_VOICES),
  localparam int OW        = $clog2(NUM_OPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  freq_inc,
  input  logic             alg_wr_en,
  input  logic [ALG_W-1:0] alg_wr_num,
  output logic [IDX_W-1:0] ph_index,
  output logic [VW-1:0]    voice_idx,
  output logic [OW-1:0]    op_idx,
  output logic [2:0]       ctl_sel,
  output logic             ctl_fb_load,
  output logic             ctl_mem_hold,
  output logic             ctl_mem_load,
  output logic [2:0]       ctl_com
);

  logic             rst_sync_n;
  logic             frame_last;
  logic [PH_W-1:0]  acc_new;
  logic [ALG_W-1:0] alg_pend_q, alg_pend_d;
  logic [ALG_W-1:0] alg_act_q, alg_act_d;
  logic             alg_act_en;
  ctl_word_t        ctl_word;

  fmseq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fmseq_slot_counter #(
    .NUM_VOICES (NUM_VOICES),
    .NUM_OPS    (NUM_OPS)
  ) u_slot_counter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .voice      (voice_idx),
    .op         (op_idx),
    .frame_last (frame_last)
  );

  fmseq_phase_ring #(
    .DEPTH (NUM_SLOTS),
    .PH_W  (PH_W)
  ) u_phase_ring (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc     (freq_inc),
    .acc_new (acc_new)
  );

  // Algorithm number: pending copy follows every write, active copy
  // loads only on the edge that ends the last slot of a frame.
  always_comb begin
    alg_pend_d = alg_wr_en ? alg_wr_num : alg_pend_q;
    alg_act_en = frame_last;
    alg_act_d  = alg_pend_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      alg_pend_q <= '0;
      alg_act_q  <= '0;
    end else begin
      alg_pend_q <= alg_pend_d;
      if (alg_act_en) alg_act_q <= alg_act_d;
    end
  end

  fmseq_alg_rom #(
    .OW (OW)
  ) u_alg_rom (
    .alg  (alg_act_q),
    .op   (op_idx),
    .word (ctl_word)
  );

  assign ph_index     = acc_new[PH_W-1 -: IDX_W];
  assign ctl_sel      = ctl_word.sel;
  assign ctl_fb_load  = ctl_word.fb_ld;
  assign ctl_mem_hold = ctl_word.mem_hold;
  assign ctl_mem_load = ctl_word.mem_ld;
  assign ctl_com      = ctl_word.com;

endmodule

// File: rtl/fmseq_sva.sv
module fmseq_sva #(
  parameter int NUM_VOICES = 16,
  parameter int NUM_OPS    = 6,
  parameter int ALG_W      = 5,
  localparam int VW = $clog2(NUM_VOICES),
  localparam int OW = $clog2(NUM_OPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VW-1:0]    voice_idx,
  input logic [OW-1:0]    op_idx,
  input logic [ALG_W-1:0] alg_act
);

  localparam logic [VW-1:0] VLAST = VW'(NUM_VOICES - 1);

  p_voice_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_idx != VLAST) |=> (voice_idx == $past(voice_idx) + VW'(1)));

  p_voice_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_idx == VLAST) |=> (voice_idx == '0));

  p_op_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_idx != VLAST) |=> $stable(op_idx));

  p_op_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_idx == VLAST && op_idx != OW'(1)) |=> (op_idx == $past(op_idx) - OW'(1)));

  p_op_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_idx == VLAST && op_idx == OW'(1)) |=> (op_idx == OW'(NUM_OPS)));

  p_op_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_idx >= OW'(1)) && (op_idx <= OW'(NUM_OPS)));

  p_alg_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(voice_idx == VLAST && op_idx == OW'(1)) |=> $stable(alg_act));

endmodule

bind fm_slot_sequencer fmseq_sva #(
  .NUM_VOICES (NUM_VOICES),
  .NUM_OPS    (NUM_OPS),
  .ALG_W      (fmseq_pkg::ALG_W)
) u_fmseq_sva (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .voice_idx (voice_idx),
  .op_idx    (op_idx),
  .alg_act   (alg_act_q)
);

// File: tb/test_fm_slot_sequencer.sv
`timescale 1ns/1ps
module test_fm_slot_sequencer;

  logic        clk;
  logic        rst_n;
  logic [21:0] freq_inc;
  logic        alg_wr_en;
  logic [4:0]  alg_wr_num;
  logic [11:0] ph_index;
  logic [3:0]  voice_idx;
  logic [2:0]  op_idx;
  logic [2:0]  ctl_sel;
  logic        ctl_fb_load;
  logic        ctl_mem_hold;
  logic        ctl_mem_load;
  logic [2:0]  ctl_com;

  fm_slot_sequencer i_fm_slot_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_inc     (freq_inc),
    .alg_wr_en    (alg_wr_en),
    .alg_wr_num   (alg_wr_num),
    .ph_index     (ph_index),
    .voice_idx    (voice_idx),
    .op_idx       (op_idx),
    .ctl_sel      (ctl_sel),
    .ctl_fb_load  (ctl_fb_load),
    .ctl_mem_hold (ctl_mem_hold),
    .ctl_mem_load (ctl_mem_load),
    .ctl_com      (ctl_com)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp;
  int n_bad;
  bit done;

  logic [21:0] m_ph [96];
  int          m_slot;
  logic [4:0]  m_pend;
  logic [4:0]  m_act;

  function automatic logic [8:0] exp_word(input logic [4:0] alg, input int op);
    logic [8:0] w;
    w = 9'd0;
    if (alg == 5'd7) begin
      case (op)
        6: w = {3'd1, 3'b000, 3'd0};
        5: w = {3'd5, 3'b001, 3'd0};
        4: w = {3'd2, 3'b111, 3'd1};
        3: w = {3'd0, 3'b001, 3'd0};
        2: w = {3'd1, 3'b010, 3'd1};
        1: w = {3'd0, 3'b011, 3'd0};
        default: w = 9'd0;
      endcase
    end else if (alg == 5'd0) begin
      case (op)
        6: w = {3'd1, 3'b100, 3'd0};
        5: w = {3'd1, 3'b000, 3'd0};
        4: w = {3'd1, 3'b000, 3'd1};
        3: w = {3'd0, 3'b001, 3'd0};
        2: w = {3'd1, 3'b010, 3'd1};
        1: w = {3'd5, 3'b011, 3'd0};
        default: w = 9'd0;
      endcase
    end else if (alg == 5'd1) begin
      case (op)
        6: w = {3'd1, 3'b000, 3'd0};
        5: w = {3'd1, 3'b000, 3'd0};
        4: w = {3'd1, 3'b000, 3'd1};
        3: w = {3'd5, 3'b001, 3'd0};
        2: w = {3'd1, 3'b110, 3'd1};
        1: w = {3'd0, 3'b011, 3'd0};
        default: w = 9'd0;
      endcase
    end
    return w;
  endfunction

  function automatic string alg_tag(input logic [4:0] alg);
    if (alg == 5'd7) return "R6";
    if (alg == 5'd0 || alg == 5'd1) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s slot=%0d actual=%0h expected=%0h", req, what, m_slot, act, exp);
    end
  endtask

  function automatic logic [8:0] got_word();
    return {ctl_sel, ctl_fb_load, ctl_mem_hold, ctl_mem_load, ctl_com};
  endfunction

  // One slot: drive at negedge, compare, then advance the model.
  task automatic step(input logic [21:0] inc, input logic we, input logic [4:0] num);
    logic [21:0] nv;
    int op_e;
    @(negedge clk);
    freq_inc   = inc;
    alg_wr_en  = we;
    alg_wr_num = num;
    #1;
    op_e = 6 - (m_slot / 16);
    nv   = m_ph[m_slot] + inc;
    check("R2", "voice", 32'(voice_idx), 32'(m_slot % 16));
    check("R3", "op", 32'(op_idx), 32'(op_e));
    check("R4", "phase", 32'(ph_index), 32'(nv[21:10]));
    check({"R5/", alg_tag(m_act)}, "ctl", 32'(got_word()), 32'(exp_word(m_act, op_e)));
    if (m_slot == 0)
      check("R9", "frame-start alg", 32'(got_word()), 32'(exp_word(m_act, 6)));
    m_ph[m_slot] = nv;
    if (we) m_pend = num;
    if (m_slot == 95) m_act = m_pend;
    m_slot = (m_slot + 1) % 96;
  endtask

  task automatic run_to(input int slot, input logic [21:0] inc);
    while (m_slot != slot) step(inc, 1'b0, 5'd0);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    void'($urandom(32'd2718));
    rst_n      = 1'b0;
    freq_inc   = 22'h3FFC00;
    alg_wr_en  = 1'b0;
    alg_wr_num = 5'd0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset presents slot 0 of algorithm 1 with cleared phases
    m_slot = 0;
    check("R1", "reset voice", 32'(voice_idx), 32'd0);
    check("R1", "reset op", 32'(op_idx), 32'd6);
    check("R1", "reset phase", 32'(ph_index), 32'h0FFF);
    check("R7", "reset ctl", 32'(got_word()), 32'(exp_word(5'd0, 6)));
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    for (int i = 0; i < 96; i++) m_ph[i] = '0;
    m_pend = 5'd0;
    m_act  = 5'd0;
    m_slot = 0;

    // R1/R4: first frame sees zero phases; then overflow past 2^22
    for (int i = 0; i < 3 * 96; i++) step(22'h200000, 1'b0, 5'd0);

    // R9: mid-frame write to algorithm 8, current frame keeps algorithm 1
    run_to(40, 22'h0001FF);
    step(22'h0001FF, 1'b1, 5'd7);
    run_to(0, 22'h0001FF);
    // R6: full frame of algorithm 8
    run_to(95, 22'h155555);
    // R9: write placed in the last slot still lands at the next slot 0
    step(22'h155555, 1'b1, 5'd1);
    run_to(30, 22'h2AAAAA);
    // R9: two writes in one frame, the later one wins
    step(22'h2AAAAA, 1'b1, 5'd20);
    run_to(70, 22'h2AAAAA);
    step(22'h2AAAAA, 1'b1, 5'd7);
    run_to(0, 22'h000400);
    run_to(95, 22'h000400);
    // R8: unpopulated algorithm code
    step(22'h000400, 1'b1, 5'd19);
    run_to(0, 22'h3FFFFF);
    run_to(0, 22'h3FFFFF);

    // Random stimulus with sparse algorithm writes
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] pick;
      logic       we;
      we = (($urandom % 40) == 0);
      case ($urandom % 4)
        0: pick = 5'd0;
        1: pick = 5'd1;
        2: pick = 5'd7;
        default: pick = 5'($urandom);
      endcase
      step(22'($urandom), we, pick);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule